// File: doc/BRIEF.md
# Shift Register Pair with Threshold-Driven FIFO Transfer

This block sits between a host and a bit-serial engine. An output shift register supplies the engine with fields of 1 to 32 bits per request, and it is refilled from a 32-bit transmit FIFO. An input shift register gathers fields of 1 to 32 bits from the engine, and it is drained into a 32-bit receive FIFO. The host writes words into the transmit FIFO and reads words out of the receive FIFO. Each side has its own full and empty flags.

Refill and drain can run on their own. A configurable bit threshold decides when the output register is treated as exhausted and when the input register is treated as complete. The engine can also request a whole-word pull or push explicitly. When a transfer cannot proceed because data or space is missing, the block raises a stall flag and changes no state in that cycle.

Each register has its own shift direction bit. The output side can be made sticky, so that it repeats its last value once it is empty. The two 4-entry FIFOs can be combined into a single 8-entry FIFO that serves only one direction.

Top module: `shreg_autoxfer`

## Requirements
- R1: After reset both FIFOs are empty and not full, `stall` is low and `out_data` is 0. The output register counts as empty (32 bits consumed) and the input register holds 0 bits.
- R2: Each FIFO holds 4 words by default and is first-in first-out. A host write to a full transmit FIFO is dropped, and only host writes fill it. A read of an empty FIFO is ignored.
- R3: With `cfg_join_rx` set, the receive FIFO holds 8 words and the transmit FIFO has no capacity, so it reports full and empty together. With only `cfg_join_tx` set, the reverse applies. When both are set, `cfg_join_rx` wins.
- R4: The threshold fields and the request length fields are 5 bits wide with values 1 to 31 taken literally, and a value of 0 means 32.
- R5: An explicit pull loads the head of the transmit FIFO into the output register and sets its consumed count to 0. It stalls when the transmit FIFO is empty.
- R6: A shift-out request of N bits returns the bits right-aligned in `out_data` after the next clock edge. With the direction bit at 1 it takes the N least significant bits and shifts right. With the direction bit at 0 it takes the N most significant bits and shifts left. Zeros fill in behind.
- R7: With autopull on, a shift-out request that finds a consumed count at or above the pull threshold first reloads from the transmit FIFO and then shifts N bits from the new word within the same cycle. If the transmit FIFO is empty, it stalls.
- R8: An explicit push writes the whole input register into the receive FIFO and clears the register and its count. It stalls when the receive FIFO is full.
- R9: A shift-in request of N bits takes the N low bits of `in_data`. With the direction bit at 1 they enter at the most significant end and the register shifts right. With the direction bit at 0 they enter at the least significant end and the register shifts left. Both counters saturate at 32.
- R10: With autopush on, a shift-in that brings the count to the push threshold or above writes the resulting word to the receive FIFO in the same cycle and clears the register. If the receive FIFO is full, it stalls.
- R11: In a stalled cycle no request takes effect. The shift registers, their counts, both FIFOs (apart from host access) and `out_data` keep their values.
- R12: A shift-out request served from an empty output register without a reload leaves `out_data` unchanged when `cfg_sticky` is 1, and returns zeros when it is 0.
- R13: When both are requested in one cycle, a pull takes precedence over a shift-out and a push takes precedence over a shift-in. The lower-priority request is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_out_right | input | 1 | Output register direction: 1 right, 0 left |
| cfg_in_right | input | 1 | Input register direction: 1 right, 0 left |
| cfg_autopull | input | 1 | Enable threshold refill of the output register |
| cfg_autopush | input | 1 | Enable threshold drain of the input register |
| cfg_sticky | input | 1 | Repeat last output value when empty |
| cfg_pull_thr | input | 5 | Refill threshold in bits, 0 means 32 |
| cfg_push_thr | input | 5 | Drain threshold in bits, 0 means 32 |
| cfg_join_rx | input | 1 | Give all storage to the receive direction |
| cfg_join_tx | input | 1 | Give all storage to the transmit direction |
| tx_wr_en | input | 1 | Host write strobe for the transmit FIFO |
| tx_wr_data | input | 32 | Host write word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_rd_en | input | 1 | Host read strobe, pops the head word |
| rx_rd_data | output | 32 | Head word of the receive FIFO |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| out_req | input | 1 | Engine shift-out request |
| out_len | input | 5 | Bits to shift out, 0 means 32 |
| out_data | output | 32 | Right-aligned bits of the last served shift-out |
| in_req | input | 1 | Engine shift-in request |
| in_len | input | 5 | Bits to shift in, 0 means 32 |
| in_data | input | 32 | Shift-in source, low bits used |
| pull_req | input | 1 | Explicit whole-word pull |
| push_req | input | 1 | Explicit whole-word push |
| stall | output | 1 | Request cannot complete this cycle |

## Verification
Some properties are checked on every cycle. A stall freezes `out_data` and the output count. An explicit pull or push that goes through zeroes the matching count. Neither count ever passes 32. An empty transmit FIFO stays empty unless the host writes to it. The bit-level results can only be shown by the bench scenarios: the field values under both directions for every length from 1 to 32, the refill and drain points at given thresholds, the FIFO capacities in each join mode, sticky against non-sticky output, and the same-cycle priority between requests.

// File: rtl/shreg_pkg.sv
// Shared types for the shift register pair: storage join mode decoding.
package shreg_pkg;
    typedef enum logic [1:0] {
        JOIN_NONE = 2'd0,
        JOIN_RX   = 2'd1,
        JOIN_TX   = 2'd2
    } join_e;

    // Receive join takes precedence when both requests are present.
    function automatic join_e pick_join(input logic to_rx, input logic to_tx);
        if (to_rx) return JOIN_RX;
        if (to_tx) return JOIN_TX;
        return JOIN_NONE;
    endfunction
endpackage

// File: rtl/shreg_fifo.sv
// Word FIFO with a runtime capacity limit.
// Storage is DEPTH_MAX words. `cap` limits how many may be held (0..DEPTH_MAX).
// Assumes DEPTH_MAX is a power of two and that `cap` changes only while empty.
// A write that arrives while full is dropped, even if a read happens in the same cycle.
module shreg_fifo #(
    parameter int DATA_W    = 32,
    parameter int DEPTH_MAX = 8,
    localparam int AW       = $clog2(DEPTH_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       cap,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH_MAX];
    logic [AW-1:0]     wp, rp;
    logic [AW:0]       cnt;
    logic              do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt >= cap);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    // Word storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end
endmodule

// File: rtl/shreg_out.sv
// Output shift register with threshold refill.
// Supplies N-bit fields (N = 1..DATA_W, already decoded) right-aligned in out_data.
// A reload comes from an explicit pull, or from autopull when the consumed count
// has reached the threshold at the time of a shift-out request. Every update is
// blocked while `hold` (the block-wide stall) is high. The local stall is raised
// when a reload is needed but the source FIFO is empty.
module shreg_out #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_right,
    input  logic              sticky,
    input  logic              autopull,
    input  logic [CNT_W-1:0]  thr,
    input  logic              req_out,
    input  logic [CNT_W-1:0]  req_n,
    input  logic              req_pull,
    input  logic              src_empty,
    input  logic [DATA_W-1:0] src_data,
    input  logic              hold,
    output logic              src_pop,
    output logic              need_stall,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    logic [DATA_W-1:0] osr, src, take, nxt_osr, msk;
    logic [CNT_W-1:0]  cnt, src_cnt, nxt_cnt, lsh;
    logic [CNT_W:0]    sum;
    logic              reload, shift_en;

    assign cnt_o = cnt;

    // Decide on a reload and pick the word the shift will operate on.
    always_comb begin
        reload     = req_pull || (req_out && autopull && (cnt >= thr));
        need_stall = reload && src_empty;
        shift_en   = req_out && !req_pull;
        src        = reload ? src_data : osr;
        src_cnt    = reload ? '0 : cnt;
        src_pop    = reload && !hold;
    end

    // Extract the field and form the shifted register and saturated count.
    always_comb begin
        lsh  = FULL_CNT - req_n;
        msk  = (req_n >= FULL_CNT) ? '1 : ((DATA_W'(1) << req_n) - 1'b1);
        if (dir_right) begin
            take    = src & msk;
            nxt_osr = src >> req_n;
        end else begin
            take    = src >> lsh;
            nxt_osr = src << req_n;
        end
        sum     = {1'b0, src_cnt} + {1'b0, req_n};
        nxt_cnt = (sum > {1'b0, FULL_CNT}) ? FULL_CNT : sum[CNT_W-1:0];
    end

    // Register update: reload and/or shift, frozen while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr      <= '0;
            cnt      <= FULL_CNT;
            out_data <= '0;
        end else if (!hold) begin
            if (shift_en) begin
                osr <= nxt_osr;
                cnt <= nxt_cnt;
                if (!(sticky && src_cnt == FULL_CNT)) out_data <= take;
            end else if (reload) begin
                osr <= src_data;
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/shreg_in.sv
// Input shift register with threshold drain.
// Accepts N-bit fields (N = 1..DATA_W, already decoded) from the low bits of
// in_data. A drain comes from an explicit push, or from autopush when the count
// after a shift reaches the threshold. A drain clears the register and count.
// Every update is blocked while `hold` (the block-wide stall) is high.
module shreg_in #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_right,
    input  logic              autopush,
    input  logic [CNT_W-1:0]  thr,
    input  logic              req_in,
    input  logic [CNT_W-1:0]  req_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              req_push,
    input  logic              dst_full,
    input  logic              hold,
    output logic              dst_push,
    output logic [DATA_W-1:0] dst_data,
    output logic              need_stall,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    logic [DATA_W-1:0] isr, ins, shifted, msk;
    logic [CNT_W-1:0]  cnt, sh_cnt, lsh;
    logic [CNT_W:0]    sum;
    logic              shift_en, drain;

    assign cnt_o = cnt;

    // Form the shifted register value and the saturated count.
    always_comb begin
        lsh  = FULL_CNT - req_n;
        msk  = (req_n >= FULL_CNT) ? '1 : ((DATA_W'(1) << req_n) - 1'b1);
        ins  = in_data & msk;
        if (dir_right) shifted = (isr >> req_n) | (ins << lsh);
        else           shifted = (isr << req_n) | ins;
        sum    = {1'b0, cnt} + {1'b0, req_n};
        sh_cnt = (sum > {1'b0, FULL_CNT}) ? FULL_CNT : sum[CNT_W-1:0];
    end

    // Decide on a drain and what gets written to the receive FIFO.
    always_comb begin
        shift_en   = req_in && !req_push;
        drain      = req_push || (shift_en && autopush && (sh_cnt >= thr));
        dst_data   = req_push ? isr : shifted;
        need_stall = drain && dst_full;
        dst_push   = drain && !hold;
    end

    // Register update: shift or clear on drain, frozen while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr <= '0;
            cnt <= '0;
        end else if (!hold) begin
            if (drain) begin
                isr <= '0;
                cnt <= '0;
            end else if (shift_en) begin
                isr <= shifted;
                cnt <= sh_cnt;
            end
        end
    end
endmodule

// File: rtl/shreg_autoxfer.sv
// Top level: output/input shift register pair with threshold FIFO transfer.
// Host writes the transmit FIFO and reads the receive FIFO. The engine issues
// shift-out, shift-in, pull and push requests. Each FIFO owns DEPTH_MAX words of
// storage, and the join mode sets how many of them may be used.
// Assumes configuration inputs are static between resets and that DATA_W and
// FIFO_DEPTH are powers of two.
module shreg_autoxfer #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    localparam int FLD_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_out_right,
    input  logic              cfg_in_right,
    input  logic              cfg_autopull,
    input  logic              cfg_autopush,
    input  logic              cfg_sticky,
    input  logic [FLD_W-1:0]  cfg_pull_thr,
    input  logic [FLD_W-1:0]  cfg_push_thr,
    input  logic              cfg_join_rx,
    input  logic              cfg_join_tx,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_full,
    output logic              rx_empty,
    input  logic              out_req,
    input  logic [FLD_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_data,
    input  logic              in_req,
    input  logic [FLD_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    input  logic              pull_req,
    input  logic              push_req,
    output logic              stall
);
    import shreg_pkg::*;

    localparam int CNT_W     = FLD_W + 1;
    localparam int DEPTH_MAX = 2 * FIFO_DEPTH;
    localparam int CAP_W     = $clog2(DEPTH_MAX) + 1;

    // Length field decode: zero stands for a full word.
    function automatic logic [CNT_W-1:0] dec_len(input logic [FLD_W-1:0] f);
        return (f == '0) ? CNT_W'(DATA_W) : {1'b0, f};
    endfunction

    join_e             jmode;
    logic [CAP_W-1:0]  tx_cap, rx_cap;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic              tx_pop, rx_push;
    logic              out_stall, in_stall;
    logic [CNT_W-1:0]  osr_cnt, isr_cnt;

    assign stall = out_stall || in_stall;

    // Capacity of each FIFO for the selected join mode.
    always_comb begin
        jmode = pick_join(cfg_join_rx, cfg_join_tx);
        case (jmode)
            JOIN_RX: begin
                tx_cap = '0;
                rx_cap = CAP_W'(DEPTH_MAX);
            end
            JOIN_TX: begin
                tx_cap = CAP_W'(DEPTH_MAX);
                rx_cap = '0;
            end
            default: begin
                tx_cap = CAP_W'(FIFO_DEPTH);
                rx_cap = CAP_W'(FIFO_DEPTH);
            end
        endcase
    end

    shreg_fifo #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX)) tx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (tx_cap),
        .wr_en   (tx_wr_en),
        .wr_data (tx_wr_data),
        .rd_en   (tx_pop),
        .rd_data (tx_head),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    shreg_fifo #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX)) rx_fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (rx_cap),
        .wr_en   (rx_push),
        .wr_data (rx_word),
        .rd_en   (rx_rd_en),
        .rd_data (rx_rd_data),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    shreg_out #(.DATA_W(DATA_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_right  (cfg_out_right),
        .sticky     (cfg_sticky),
        .autopull   (cfg_autopull),
        .thr        (dec_len(cfg_pull_thr)),
        .req_out    (out_req),
        .req_n      (dec_len(out_len)),
        .req_pull   (pull_req),
        .src_empty  (tx_empty),
        .src_data   (tx_head),
        .hold       (stall),
        .src_pop    (tx_pop),
        .need_stall (out_stall),
        .out_data   (out_data),
        .cnt_o      (osr_cnt)
    );

    shreg_in #(.DATA_W(DATA_W)) in_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_right  (cfg_in_right),
        .autopush   (cfg_autopush),
        .thr        (dec_len(cfg_push_thr)),
        .req_in     (in_req),
        .req_n      (dec_len(in_len)),
        .in_data    (in_data),
        .req_push   (push_req),
        .dst_full   (rx_full),
        .hold       (stall),
        .dst_push   (rx_push),
        .dst_data   (rx_word),
        .need_stall (in_stall),
        .cnt_o      (isr_cnt)
    );
endmodule

// File: rtl/shreg_autoxfer_chk.sv
// Cycle checker for shreg_autoxfer, attached by bind. Observes ports and the
// two shift counts; it drives nothing.
module shreg_autoxfer_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_wr_en,
    input logic              tx_empty,
    input logic              stall,
    input logic              pull_req,
    input logic              push_req,
    input logic [DATA_W-1:0] out_data,
    input logic [CNT_W-1:0]  osr_cnt,
    input logic [CNT_W-1:0]  isr_cnt
);
    // R11: a stalled cycle leaves the output field untouched.
    a_r11_stall_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(out_data));

    // R11: a stalled cycle leaves the output consumed count untouched.
    a_r11_stall_holds_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(osr_cnt));

    // R2: only the host can make the transmit FIFO non-empty.
    a_r2_tx_fill_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !tx_wr_en) |=> tx_empty);

    // R5: a pull that goes through leaves nothing consumed.
    a_r5_pull_zeroes_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_req && !stall) |=> (osr_cnt == '0));

    // R8: a push that goes through empties the input register.
    a_r8_push_zeroes_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !stall) |=> (isr_cnt == '0));

    // R9: both counts saturate at a full word.
    a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_cnt <= CNT_W'(DATA_W)) && (isr_cnt <= CNT_W'(DATA_W)));
endmodule

bind shreg_autoxfer shreg_autoxfer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_wr_en (tx_wr_en),
    .tx_empty (tx_empty),
    .stall    (stall),
    .pull_req (pull_req),
    .push_req (push_req),
    .out_data (out_data),
    .osr_cnt  (osr_cnt),
    .isr_cnt  (isr_cnt)
);

// File: tb/shreg_autoxfer_tb_top.sv
// Self-checking bench: length and direction sweeps plus threshold, join,
// sticky, stall and priority scenarios. Inputs change 1 ns after a rising edge,
// and outputs are sampled there too.
module shreg_autoxfer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_out_right, cfg_in_right, cfg_autopull, cfg_autopush, cfg_sticky;
    logic [4:0]  cfg_pull_thr, cfg_push_thr;
    logic        cfg_join_rx, cfg_join_tx;
    logic        tx_wr_en;
    logic [31:0] tx_wr_data;
    logic        tx_full, tx_empty;
    logic        rx_rd_en;
    logic [31:0] rx_rd_data;
    logic        rx_full, rx_empty;
    logic        out_req;
    logic [4:0]  out_len;
    logic [31:0] out_data;
    logic        in_req;
    logic [4:0]  in_len;
    logic [31:0] in_data;
    logic        pull_req, push_req, stall;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    shreg_autoxfer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_out_right(cfg_out_right), .cfg_in_right(cfg_in_right),
        .cfg_autopull(cfg_autopull), .cfg_autopush(cfg_autopush),
        .cfg_sticky(cfg_sticky), .cfg_pull_thr(cfg_pull_thr),
        .cfg_push_thr(cfg_push_thr), .cfg_join_rx(cfg_join_rx),
        .cfg_join_tx(cfg_join_tx),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .out_req(out_req), .out_len(out_len), .out_data(out_data),
        .in_req(in_req), .in_len(in_len), .in_data(in_data),
        .pull_req(pull_req), .push_req(push_req), .stall(stall)
    );

    function automatic logic [31:0] msk(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tx_wr_en = 0; rx_rd_en = 0; out_req = 0; in_req = 0;
        pull_req = 0; push_req = 0; out_len = 0; in_len = 0;
        in_data = 0; tx_wr_data = 0;
    endtask

    task automatic set_cfg(bit oright, bit iright, bit apull, bit apush, bit stk,
                           logic [4:0] pthr, logic [4:0] uthr, bit jrx, bit jtx);
        cfg_out_right = oright; cfg_in_right = iright;
        cfg_autopull = apull; cfg_autopush = apush; cfg_sticky = stk;
        cfg_pull_thr = pthr; cfg_push_thr = uthr;
        cfg_join_rx = jrx; cfg_join_tx = jtx;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic host_write(logic [31:0] w);
        tx_wr_en = 1; tx_wr_data = w; tick(); tx_wr_en = 0;
    endtask

    task automatic host_read(output logic [31:0] w);
        w = rx_rd_data; rx_rd_en = 1; tick(); rx_rd_en = 0;
    endtask

    task automatic eng_pull();
        pull_req = 1; tick(); pull_req = 0;
    endtask

    task automatic eng_push();
        push_req = 1; tick(); push_req = 0;
    endtask

    task automatic eng_out(int n);
        out_req = 1; out_len = 5'(n); tick(); out_req = 0;
    endtask

    task automatic eng_in(int n, logic [31:0] d);
        in_req = 1; in_len = 5'(n); in_data = d; tick(); in_req = 0;
    endtask

    logic [31:0] w, r, a, b, d, e;

    initial begin
        set_cfg(1, 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();

        // R1: reset state
        check("R1 tx_empty", 32'(tx_empty), 32'd1);
        check("R1 rx_empty", 32'(rx_empty), 32'd1);
        check("R1 tx_full", 32'(tx_full), 32'd0);
        check("R1 rx_full", 32'(rx_full), 32'd0);
        check("R1 stall", 32'(stall), 32'd0);
        check("R1 out_data", out_data, 32'd0);

        // R6 R5: output field sweep over both directions and every length
        for (int dir = 0; dir < 2; dir++) begin
            set_cfg(dir[0], 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
            do_reset();
            for (int n = 1; n <= 32; n++) begin
                w = (32'hA5C3_0F1E ^ (32'(n) * 32'h0107_0B0D)) + 32'(dir);
                host_write(w);
                eng_pull();
                check("R5 tx_empty after pull", 32'(tx_empty), 32'd1);
                eng_out(n);
                check("R6 first field", out_data,
                      dir ? (w & msk(n)) : (w >> (32 - n)));
                if (n < 32) begin
                    eng_out(32 - n);
                    check("R6 remainder field", out_data,
                          dir ? (w >> n) : (w & msk(32 - n)));
                end
            end
        end

        // R8 R9: input field sweep over both directions and every length
        for (int dir = 0; dir < 2; dir++) begin
            set_cfg(1, dir[0], 0, 0, 0, 5'd0, 5'd0, 0, 0);
            do_reset();
            for (int n = 1; n <= 32; n++) begin
                d = 32'h3C96_E1D2 ^ (32'(n) * 32'h0913_0527);
                eng_in(n, d);
                eng_push();
                check("R8 rx holds pushed word", 32'(rx_empty), 32'd0);
                host_read(r);
                check("R9 entered field", r,
                      dir ? ((d & msk(n)) << (32 - n)) : (d & msk(n)));
            end
        end

        // R2 R5: default capacity, dropped write, order, pull stall when empty
        set_cfg(1, 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        for (int i = 0; i < 5; i++) begin
            host_write(32'h1000_0000 + 32'(i));
            if (i == 2) check("R2 not full at 3", 32'(tx_full), 32'd0);
        end
        check("R2 full at 4", 32'(tx_full), 32'd1);
        for (int i = 0; i < 4; i++) begin
            eng_pull();
            eng_out(32);
            check("R2 fifo order", out_data, 32'h1000_0000 + 32'(i));
        end
        check("R2 fifth write dropped", 32'(tx_empty), 32'd1);
        pull_req = 1; #1;
        check("R5 pull stalls on empty", 32'(stall), 32'd1);
        tick(); pull_req = 0;

        // R3: transmit join gives 8 words and no receive space
        set_cfg(1, 1, 0, 0, 0, 5'd0, 5'd0, 0, 1);
        do_reset();
        for (int i = 0; i < 9; i++) begin
            host_write(32'h2000_0000 + 32'(i));
            if (i == 6) check("R3 tx not full at 7", 32'(tx_full), 32'd0);
        end
        check("R3 tx full at 8", 32'(tx_full), 32'd1);
        check("R3 rx zero capacity", 32'(rx_full), 32'd1);
        push_req = 1; #1;
        check("R3 push stalls with no rx", 32'(stall), 32'd1);
        tick(); push_req = 0;
        for (int i = 0; i < 8; i++) begin
            eng_pull();
            eng_out(32);
            check("R3 joined tx order", out_data, 32'h2000_0000 + 32'(i));
        end
        check("R3 ninth write dropped", 32'(tx_empty), 32'd1);

        // R3 R10: both joins set, receive wins; autopush fills 8 words
        set_cfg(1, 0, 0, 1, 0, 5'd8, 5'd8, 1, 1);
        do_reset();
        check("R3 tx zero capacity", 32'(tx_full), 32'd1);
        host_write(32'hDEAD_BEEF);
        check("R3 tx write ignored", 32'(tx_empty), 32'd1);
        for (int i = 0; i < 8; i++) begin
            eng_in(8, 32'(8'h40 + i));
            if (i == 6) check("R3 rx not full at 7", 32'(rx_full), 32'd0);
        end
        check("R3 rx full at 8", 32'(rx_full), 32'd1);
        for (int i = 0; i < 8; i++) begin
            host_read(r);
            check("R10 joined rx word", r, 32'(8'h40 + i));
        end

        // R7 R11: autopull at an 8-bit threshold, then stall on empty
        set_cfg(1, 1, 1, 0, 0, 5'd8, 5'd0, 0, 0);
        do_reset();
        a = 32'h1234_56C7; b = 32'h89AB_CD5E;
        host_write(a); host_write(b);
        eng_out(8);
        check("R7 reload on first request", out_data, a & 32'hFF);
        eng_out(8);
        check("R7 reload at threshold", out_data, b & 32'hFF);
        check("R7 both words consumed", 32'(tx_empty), 32'd1);
        out_req = 1; out_len = 5'd8; #1;
        check("R7 stall when source empty", 32'(stall), 32'd1);
        tick(); out_req = 0;
        check("R11 out_data held in stall", out_data, b & 32'hFF);
        host_write(a);
        eng_out(8);
        check("R11 stalled request left state", out_data, a & 32'hFF);

        // R4: threshold field 0 means 32 bits
        set_cfg(1, 1, 1, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        host_write(a); host_write(b);
        eng_out(16);
        check("R4 low half", out_data, a & 32'hFFFF);
        eng_out(16);
        check("R4 high half no reload", out_data, a >> 16);
        eng_out(16);
        check("R4 reload after 32", out_data, b & 32'hFFFF);

        // R12: sticky output on an empty register
        set_cfg(0, 1, 0, 0, 1, 5'd0, 5'd0, 0, 0);
        do_reset();
        host_write(a); eng_pull(); eng_out(32);
        check("R12 full word left", out_data, a);
        eng_out(5);
        check("R12 sticky repeats", out_data, a);
        set_cfg(0, 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        host_write(a); eng_pull(); eng_out(32);
        eng_out(5);
        check("R12 non-sticky zeros", out_data, 32'd0);

        // R9: saturation past 32 consumed bits
        set_cfg(1, 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        host_write(a); eng_pull();
        eng_out(20);
        eng_out(20);
        check("R9 shifted past end", out_data, a >> 20);
        eng_out(4);
        check("R9 empty gives zeros", out_data, 32'd0);

        // R10 R11: autopush at 8 bits, left, stall on full receive FIFO
        set_cfg(1, 0, 0, 1, 0, 5'd0, 5'd8, 0, 0);
        do_reset();
        for (int i = 0; i < 4; i++) eng_in(8, 32'hFFFF_FF00 | 32'(8'hA0 + i));
        check("R10 rx full after 4", 32'(rx_full), 32'd1);
        in_req = 1; in_len = 5'd8; in_data = 32'h77; #1;
        check("R10 stall on full", 32'(stall), 32'd1);
        tick(); in_req = 0;
        for (int i = 0; i < 4; i++) begin
            host_read(r);
            check("R10 autopushed byte", r, 32'(8'hA0 + i));
        end
        eng_in(8, 32'h5A);
        host_read(r);
        check("R11 stalled shift-in ignored", r, 32'h5A);

        // R4: push threshold 0 means 32 bits, right direction
        set_cfg(1, 1, 0, 1, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        eng_in(16, 32'h0000_BEEF);
        check("R4 no push at 16 bits", 32'(rx_empty), 32'd1);
        eng_in(16, 32'h0000_CAFE);
        host_read(r);
        check("R4 push at 32 bits", r, 32'hCAFE_BEEF);

        // R13: pull beats shift-out, push beats shift-in
        set_cfg(1, 1, 0, 0, 0, 5'd0, 5'd0, 0, 0);
        do_reset();
        host_write(a); host_write(b);
        eng_pull(); eng_out(8);
        pull_req = 1; out_req = 1; out_len = 5'd8; tick();
        pull_req = 0; out_req = 0;
        check("R13 shift-out ignored under pull", out_data, a & 32'hFF);
        eng_out(32);
        check("R13 pulled word intact", out_data, b);
        d = 32'h0000_00C3; e = 32'h0000_005D;
        eng_in(8, d);
        push_req = 1; in_req = 1; in_len = 5'd8; in_data = e; tick();
        push_req = 0; in_req = 0;
        eng_push();
        host_read(r);
        check("R13 push took register", r, d << 24);
        host_read(r);
        check("R13 shift-in ignored under push", r, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule